// File: doc/BRIEF.md
# Byte-Addressed Load/Store Unit with Range and Alignment Faults

This block sits between a processor core's load/store stage and a byte-addressed RAM. It takes one request per cycle: a read or a write of a byte, a halfword or a word. It checks the address against the configured memory size and against the natural alignment of the access size. If the access is legal, it places the write data into the right bytes, or it gathers the read data from them. The byte order comes from an input that can change with every request. Loads narrower than a word can be zero-extended or sign-extended to 32 bits.

Every request gets exactly one response on the following cycle. The response carries the read data and a two-bit fault code. Out-of-range and misaligned accesses are reported as two separate fault classes. The range check wins when both apply. A faulting access never touches the RAM and always returns zero data.

The RAM is held inside the block as four byte-lane register arrays. The legal address space is set by `MEM_BYTES`, which defaults to 2^23 bytes. The backing store depth is set independently by `BANK_WORDS` (32-bit words). Legal addresses at or above `4*BANK_WORDS` alias onto the store modulo its size.

Top module: `mem_access_unit`

## Requirements
- R1: Each request accepted with `req_valid` high produces `rsp_valid` high on exactly the next clock cycle. A cycle without a request produces no response on the next cycle.
- R2: An access whose unsigned 32-bit address is greater than or equal to `MEM_BYTES` responds with fault code 01 (range). This holds whatever the size and alignment.
- R3: An in-range halfword access (size 01) with address bit 0 set responds with fault code 10 (alignment). So does an in-range word access (size 10, and size 11, which is handled as a word) with either of address bits 1:0 set.
- R4: An in-range byte access (size 00) never faults. An in-range aligned access responds with fault code 00.
- R5: A write that responds with a nonzero fault code leaves every byte of the memory unchanged.
- R6: A faulting read returns all-zero read data. Every write response also carries all-zero read data.
- R7: With `big_endian` high, the byte at the lowest address of a halfword or word is its most significant byte, on both writes and reads.
- R8: With `big_endian` low, the byte at the lowest address of a halfword or word is its least significant byte, on both writes and reads.
- R9: The byte order is taken from `big_endian` on each request. A word written in one order and read in the other comes back with its four bytes reversed.
- R10: With `req_signed` high, a byte load is sign-extended from bit 7 and a halfword load from bit 15. With it low, they are zero-extended. Word loads are unaffected by `req_signed`.
- R11: A byte write changes only the addressed byte, and a halfword write only its two bytes. They take their data from `req_wdata[7:0]` and `req_wdata[15:0]` respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 word |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data, right-aligned for narrow sizes |
| req_signed | input | 1 | Sign-extend narrow loads |
| big_endian | input | 1 | Byte order for this request, 1 = big-endian |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Load result, zero on writes and faults |
| rsp_fault | output | 2 | 00 none, 01 range, 10 alignment |

## Verification
The fault code and the read data are registered, so they are due one rising edge after the request. Stores land in the RAM at that same edge, so a store becomes visible only to a request made on a later cycle. The bench drives each request on a falling edge and samples the response on the next falling edge, which lies midway between that capture edge and the following one. Store effects are judged only through read requests issued afterwards. Read-backs cover both the written bytes and their neighbours, including writes that faulted.

// File: rtl/mau_pkg.sv
package mau_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_RANGE = 2'b01,
    FLT_ALIGN = 2'b10
  } fault_e;

  // Address beyond the legal space (unsigned compare, 33 bits wide).
  function automatic logic past_limit(input logic [31:0] addr, input logic [32:0] limit);
    return {1'b0, addr} >= limit;
  endfunction

  // Natural alignment rule per access size.
  function automatic logic off_grain(input logic [1:0] size, input logic [1:0] low);
    case (size)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return low[0];
      default: return |low;
    endcase
  endfunction

  // Which byte lanes a write touches; lane k holds the byte at offset k.
  function automatic logic [3:0] lane_mask(input logic [1:0] size, input logic [1:0] off);
    case (size)
      SZ_BYTE: return 4'b0001 << off;
      SZ_HALF: return off[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] swap4(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  // Spread write data over lanes; the mask picks the lanes that are used.
  function automatic logic [31:0] spread(input logic [1:0] size, input logic be,
                                         input logic [31:0] wd);
    logic [7:0] first, second;
    first  = be ? wd[15:8] : wd[7:0];
    second = be ? wd[7:0]  : wd[15:8];
    case (size)
      SZ_BYTE: return {4{wd[7:0]}};
      SZ_HALF: return {second, first, second, first};
      default: return be ? swap4(wd) : wd;
    endcase
  endfunction

  // Collect read data from lanes into a right-aligned, extended value.
  function automatic logic [31:0] gather(input logic [1:0] size, input logic [1:0] off,
                                         input logic be, input logic sgn,
                                         input logic [31:0] lanes);
    logic [7:0]  b, first, second;
    logic [15:0] h;
    b      = lanes[8*off +: 8];
    first  = lanes[16*off[1] +: 8];
    second = lanes[16*off[1] + 8 +: 8];
    h      = be ? {first, second} : {second, first};
    case (size)
      SZ_BYTE: return {{24{sgn & b[7]}}, b};
      SZ_HALF: return {{16{sgn & h[15]}}, h};
      default: return be ? swap4(lanes) : lanes;
    endcase
  endfunction

endpackage

// File: rtl/mau_check.sv
module mau_check
  import mau_pkg::*;
#(
  parameter longint unsigned MEM_BYTES = 64'd8388608
) (
  input  logic [31:0] addr,
  input  logic [1:0]  size,
  output logic        range_hit,
  output logic        align_hit,
  output logic [1:0]  fault
);
  localparam logic [32:0] LIMIT = 33'(MEM_BYTES);

  always_comb begin
    range_hit = past_limit(addr, LIMIT);
    align_hit = off_grain(size, addr[1:0]);
    if (range_hit)      fault = FLT_RANGE;
    else if (align_hit) fault = FLT_ALIGN;
    else                fault = FLT_NONE;
  end
endmodule

// File: rtl/mau_lanes.sv
module mau_lanes
  import mau_pkg::*;
(
  input  logic [1:0]  size,
  input  logic [1:0]  off,
  input  logic        be,
  input  logic        sgn,
  input  logic [31:0] wdata,
  input  logic [31:0] rd_lanes,
  output logic [3:0]  wr_mask,
  output logic [31:0] wr_lanes,
  output logic [31:0] rd_value
);
  always_comb begin
    wr_mask  = lane_mask(size, off);
    wr_lanes = spread(size, be, wdata);
    rd_value = gather(size, off, be, sgn, rd_lanes);
  end
endmodule

// File: rtl/mau_store.sv
module mau_store #(
  parameter int BANK_WORDS = 16,
  localparam int IDX_W = $clog2(BANK_WORDS)
) (
  input  logic             clk,
  input  logic [3:0]       we,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wr_lanes,
  output logic [31:0]      rd_lanes
);
  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [7:0] cells [BANK_WORDS];
    always_ff @(posedge clk) begin
      if (we[k]) cells[idx] <= wr_lanes[8*k +: 8];
    end
    assign rd_lanes[8*k +: 8] = cells[idx];
  end
endmodule

// File: rtl/mem_access_unit.sv
module mem_access_unit
  import mau_pkg::*;
#(
  parameter longint unsigned MEM_BYTES  = 64'd8388608,
  parameter int              BANK_WORDS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic        req_signed,
  input  logic        big_endian,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic [1:0]  rsp_fault
);
  localparam int IDX_W = $clog2(BANK_WORDS);

  // Named internal events for the assertions.
  logic        range_hit, align_hit;
  logic [1:0]  fault_now;
  logic        access_ok;
  logic [3:0]  lane_sel, store_we;
  logic [31:0] lanes_w, lanes_r, load_value;

  mau_check #(.MEM_BYTES(MEM_BYTES)) u_check (
    .addr(req_addr), .size(req_size),
    .range_hit(range_hit), .align_hit(align_hit), .fault(fault_now)
  );

  mau_lanes u_lanes (
    .size(req_size), .off(req_addr[1:0]), .be(big_endian), .sgn(req_signed),
    .wdata(req_wdata), .rd_lanes(lanes_r),
    .wr_mask(lane_sel), .wr_lanes(lanes_w), .rd_value(load_value)
  );

  assign access_ok = req_valid && (fault_now == FLT_NONE);
  assign store_we  = (access_ok && req_write) ? lane_sel : 4'b0000;

  mau_store #(.BANK_WORDS(BANK_WORDS)) u_store (
    .clk(clk), .we(store_we), .idx(req_addr[2 +: IDX_W]),
    .wr_lanes(lanes_w), .rd_lanes(lanes_r)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_fault <= FLT_NONE;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid ? fault_now : FLT_NONE;
      rsp_rdata <= (access_ok && !req_write) ? load_value : '0;
    end
  end

  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_range_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && range_hit) |=> (rsp_fault == FLT_RANGE));
  p_align_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !range_hit && align_hit) |=> (rsp_fault == FLT_ALIGN));
  p_byte_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !range_hit && req_size == SZ_BYTE) |=> (rsp_fault == FLT_NONE));
  p_fault_no_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && (range_hit || align_hit)) |-> (store_we == 4'b0000));
  p_fault_zero_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_rdata == 32'd0));
  p_write_zero_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_rdata == 32'd0));
  p_single_lane_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == SZ_BYTE) |-> $onehot0(store_we));
endmodule

// File: tb/mem_access_unit_bench.sv
module mem_access_unit_bench;
  localparam int NB = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0, big_endian = 1'b0;
  logic [1:0] req_size = 2'b00;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0] rsp_fault;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] model [NB];

  always #10 clk = ~clk;

  mem_access_unit #(.MEM_BYTES(64'd64), .BANK_WORDS(16)) u_mem_access_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_signed(req_signed), .big_endian(big_endian),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic logic [1:0] exp_fault(input int a, input int sz);
    if (a >= NB) return 2'b01;
    if (sz == 1 && (a % 2) != 0) return 2'b10;
    if (sz >= 2 && (a % 4) != 0) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [31:0] exp_read(input int a, input int sz, input bit be, input bit sg);
    int n = nbytes(sz);
    longint v = 0;
    for (int i = 0; i < n; i++) begin
      if (be) v = v * 256 + model[a + i];
      else    v = v + (longint'(model[a + i]) << (8 * i));
    end
    if (sg && n < 4 && v >= (longint'(1) << (8 * n - 1))) v = v - (longint'(1) << (8 * n));
    return v[31:0];
  endfunction

  // Drive at the current falling edge; sample at the next falling edge.
  task automatic access(input bit wr, input int sz, input int a, input logic [31:0] wd,
                        input bit be, input bit sg,
                        output logic [31:0] rd, output logic [1:0] flt, output logic vld);
    req_valid = 1'b1; req_write = wr; req_size = 2'(sz); req_addr = 32'(a);
    req_wdata = wd; big_endian = be; req_signed = sg;
    @(negedge clk);
    rd = rsp_rdata; flt = rsp_fault; vld = rsp_valid;
    req_valid = 1'b0;
  endtask

  task automatic check_read(input int a, input int sz, input bit be, input bit sg);
    logic [31:0] rd; logic [1:0] flt; logic vld;
    logic [1:0] ef;
    string tag;
    ef = exp_fault(a, sz);
    access(0, sz, a, 32'hDEAD_BEEF, be, sg, rd, flt, vld);
    chk("R1 rsp_valid", 32'(vld), 32'd1);
    tag = (a >= NB) ? "R2 fault" : (ef != 0) ? "R3 fault" : "R4 fault";
    chk(tag, 32'(flt), 32'(ef));
    if (ef != 0) chk("R6 faulting read data", rd, 32'd0);
    else if (sz < 2 && sg) chk("R10 extended load", rd, exp_read(a, sz, be, sg));
    else chk(be ? "R7 big-endian read" : "R8 little-endian read", rd, exp_read(a, sz, be, sg));
  endtask

  task automatic do_write(input int a, input int sz, input bit be, input logic [31:0] wd);
    logic [31:0] rd; logic [1:0] flt; logic vld;
    logic [1:0] ef;
    int n;
    ef = exp_fault(a, sz);
    n = nbytes(sz);
    access(1, sz, a, wd, be, 0, rd, flt, vld);
    chk((a >= NB) ? "R2 write fault" : "R3 write fault", 32'(flt), 32'(ef));
    chk("R6 write data zero", rd, 32'd0);
    if (ef == 0)
      for (int i = 0; i < n; i++)
        model[a + i] = be ? wd[8*(n-1-i) +: 8] : wd[8*i +: 8];
  endtask

  initial begin
    logic [31:0] rd; logic [1:0] flt; logic vld;
    repeat (3) @(negedge clk);
    chk("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 reset rsp_fault", 32'(rsp_fault), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle no response", 32'(rsp_valid), 32'd0);

    // Fill every byte with byte writes in alternating byte order.
    for (int a = 0; a < NB; a++) do_write(a, 0, a[0], 32'(a * 37 + 131));

    // Exhaustive reads over address, size, order and extension.
    for (int a = 0; a < NB + 8; a++)
      for (int sz = 0; sz < 4; sz++)
        for (int be = 0; be < 2; be++)
          for (int sg = 0; sg < 2; sg++)
            check_read(a, sz, be[0], sg[0]);

    // Writes of every size and order, then read back the surrounding word bytewise.
    for (int a = 0; a < NB + 8; a++)
      for (int sz = 0; sz < 4; sz++)
        for (int be = 0; be < 2; be++) begin
          int base;
          do_write(a, sz, be[0], 32'h9C35_71E2 ^ 32'(a * 32'h0103_0507 + sz * 17 + be * 5));
          base = (a & ~3) % NB;
          for (int i = 0; i < 4; i++) begin
            access(0, 0, base + i, 0, 0, 0, rd, flt, vld);
            chk((exp_fault(a, sz) != 0) ? "R5 memory kept" : "R11 byte contents",
                rd, 32'(model[base + i]));
          end
        end

    // Byte order switched between write and read of the same word.
    do_write(8, 2, 1, 32'h1122_3344);
    access(0, 2, 8, 0, 0, 0, rd, flt, vld);
    chk("R9 order swap", rd, 32'h4433_2211);
    access(0, 2, 8, 0, 1, 1, rd, flt, vld);
    chk("R10 word unaffected by signed", rd, 32'h1122_3344);
    do_write(12, 1, 0, 32'hFFFF_80F0);
    access(0, 1, 12, 0, 0, 1, rd, flt, vld);
    chk("R10 half sign", rd, 32'hFFFF_80F0);
    access(0, 0, 12, 0, 0, 1, rd, flt, vld);
    chk("R10 byte sign", rd, 32'hFFFF_FFF0);
    access(0, 0, 12, 0, 0, 0, rd, flt, vld);
    chk("R10 byte zero-extend", rd, 32'h0000_00F0);
    access(0, 2, 32'h7FFF_FFFC, 0, 0, 0, rd, flt, vld);
    chk("R2 far address", 32'(flt), 32'd1);
    @(negedge clk);
    chk("R1 idle after request", 32'(rsp_valid), 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd190000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule